// File: doc/BRIEF.md
# Stable Object Memory Controller

This controller guards a primary memory bank on behalf of one processor. It holds a small table of stable objects, each a contiguous run of word addresses with a base and a length. The processor declares an object, opens it to gain access, and may close it again. Every processor access is checked against the bounds of the objects that are open at that moment. An access that lands in no open object counts as a processor fault.

A commit first seals the transaction by closing every object for one cycle. A copy engine then walks the table in ascending entry order. For each object that was written since the last copy, it issues the object's word addresses one per accepted cycle on a word-serial copy port. The external datapath moves those words from the primary bank to the backup bank. An object's modified mark is cleared once its last word is accepted.

A watchdog expects a regular kick from the processor. A watchdog timeout or a faulty access disconnects the processor for good, until reset. The recovery depends on the phase in which the failure occurs. During the working phase, the modified objects are copied the other way, from backup to primary, so the pending update is discarded. During the copy phase, the copy restarts from the first entry and runs to completion.

Top module: `stm_ctrl`

## Requirements
- R1: After reset the phase is idle (code 0), the processor is connected (`cpu_fail` low) and the copy port is idle. A declare command (op 1) loads an entry's base and length and leaves that entry closed and unmodified.
- R2: An open command (op 2) on an entry of nonzero length makes every address from base to base+length-1 accessible (`acc_ok` high) and moves the phase from idle to working (code 1). A write to an accessible address marks each open object that contains that address as modified.
- R3: An access that falls in no open object has `acc_ok` low. This covers an address one past an object's end and an address inside an object hidden by a close command (op 3). Such an access raises `cpu_fail` at the next clock edge.
- R4: A commit command (op 4) gives exactly one precommit cycle (phase code 2) that closes all objects, followed by the copy phase (code 3).
- R5: The copy phase emits, in ascending entry order and ascending word order, the addresses of exactly the modified objects with `cp_dir` = 0 (primary to backup). It then returns to idle with all marks cleared, so a second commit emits nothing.
- R6: A failure in the idle or working phase enters rollback (code 4). Rollback closes all objects and emits the modified objects' addresses with `cp_dir` = 1 (backup to primary), then returns to idle.
- R7: Once `cpu_fail` is high it stays high until reset. While it is high, no access is accepted and every command is rejected.
- R8: A failure during the copy phase keeps the copy phase and restarts the walk from entry 0. Objects already finished are not repeated; the interrupted object is sent again from its first word. Idle follows only after the full walk.
- R9: Commands issued during precommit, copy or rollback are rejected (`cmd_rej` high in the same cycle) and change nothing.
- R10: If `wd_kick` stays low for `WD_LIMIT` consecutive cycles, `cpu_fail` rises.
- R11: While `cp_ready` is low, a pending copy address is held with `cp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 declare, 2 open, 3 close, 4 commit |
| cmd_idx | input | IW | Object table entry |
| cmd_base | input | AW | Base word address (declare) |
| cmd_len | input | LW | Length in words (declare) |
| cmd_rej | output | 1 | Command refused this cycle |
| acc_valid | input | 1 | Processor access strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | AW | Access word address |
| acc_ok | output | 1 | Access is inside an open object |
| wd_kick | input | 1 | Watchdog restart from the processor |
| cp_ready | input | 1 | Copy port accepts a word this cycle |
| cp_valid | output | 1 | Copy address valid |
| cp_dir | output | 1 | 0 primary to backup, 1 backup to primary |
| cp_addr | output | AW | Word address to copy |
| phase | output | 3 | 0 idle, 1 working, 2 precommit, 3 copy, 4 rollback |
| cpu_fail | output | 1 | Processor disconnected, failure signalled to the backup side |

## Verification
A stale open bit or a wrong bound shows up at once on `acc_ok` and, one edge later, as a spurious `cpu_fail`. A lost or stuck modified mark changes the address stream on the copy port. The copy stream would then repeat, skip or reorder words, and the scoreboard detects this at the first bad transfer. A wrong recovery choice shows up as the wrong `cp_dir`, or as a phase that does not follow the expected sequence within a few cycles after the fault.

// File: rtl/stm_pkg.sv
package stm_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_WORK = 3'd1,
      PH_PRE  = 3'd2,
      PH_COPY = 3'd3,
      PH_ROLL = 3'd4
   } phase_e;

   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_DEF    = 3'd1,
      OP_OPEN   = 3'd2,
      OP_CLOSE  = 3'd3,
      OP_COMMIT = 3'd4
   } op_e;
endpackage

// File: rtl/stm_obj_table.sv
module stm_obj_table #(
   parameter int N  = 8,
   parameter int AW = 16,
   parameter int LW = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  def_en,
   input  logic                  open_en,
   input  logic                  close_en,
   input  logic [IW-1:0]         idx,
   input  logic [AW-1:0]         base_in,
   input  logic [LW-1:0]         len_in,
   input  logic                  close_all,
   input  logic                  wr_en,
   input  logic [AW-1:0]         addr,
   input  logic [N-1:0]          clr_mod,
   output logic [N-1:0]          hit,
   output logic [N-1:0]          open_q,
   output logic [N-1:0]          mod_q,
   output logic [N-1:0][AW-1:0]  base_q,
   output logic [N-1:0][LW-1:0]  len_q
);
   if (N < 1) begin : g_bad_n
      $error("stm_obj_table: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic [AW:0] lim;
      logic        sel;
      assign lim    = {1'b0, base_q[i]} + (AW+1)'(len_q[i]);
      assign sel    = (idx == IW'(i));
      assign hit[i] = open_q[i] && ({1'b0, addr} >= {1'b0, base_q[i]}) && ({1'b0, addr} < lim);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q[i] <= 1'b0;
            mod_q[i]  <= 1'b0;
            base_q[i] <= '0;
            len_q[i]  <= '0;
         end else if (def_en && sel) begin
            base_q[i] <= base_in;
            len_q[i]  <= len_in;
            open_q[i] <= 1'b0;
            mod_q[i]  <= 1'b0;
         end else begin
            if (close_all || (close_en && sel))
               open_q[i] <= 1'b0;
            else if (open_en && sel && len_q[i] != '0)
               open_q[i] <= 1'b1;
            if (clr_mod[i])
               mod_q[i] <= 1'b0;
            else if (wr_en && hit[i])
               mod_q[i] <= 1'b1;
         end
      end
   end

   // R4: sealing leaves nothing open
   assert_seal_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      close_all |=> (open_q == '0));
endmodule

// File: rtl/stm_copy_engine.sv
module stm_copy_engine #(
   parameter int N  = 8,
   parameter int AW = 16,
   parameter int LW = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  start_dir,
   input  logic [N-1:0]          mod_q,
   input  logic [N-1:0][AW-1:0]  base_q,
   input  logic [N-1:0][LW-1:0]  len_q,
   input  logic                  cp_ready,
   output logic                  cp_valid,
   output logic                  cp_dir,
   output logic [AW-1:0]         cp_addr,
   output logic [N-1:0]          clr_mod,
   output logic                  done
);
   logic          active;
   logic          dir_q;
   logic [IW-1:0] idx;
   logic [LW-1:0] off;
   logic          last_ent, obj_end, step;

   assign last_ent = (idx == IW'(N-1));
   assign cp_valid = active && mod_q[idx];
   assign cp_addr  = base_q[idx] + AW'(off);
   assign cp_dir   = dir_q;
   assign obj_end  = cp_valid && cp_ready && (off == len_q[idx] - LW'(1));
   assign step     = active && (!mod_q[idx] || obj_end);
   assign done     = !start && step && last_ent;

   always_comb begin
      clr_mod = '0;
      if (!start && obj_end) clr_mod[idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         dir_q  <= 1'b0;
         idx    <= '0;
         off    <= '0;
      end else if (start) begin
         active <= 1'b1;
         dir_q  <= start_dir;
         idx    <= '0;
         off    <= '0;
      end else if (active) begin
         if (step) begin
            off <= '0;
            if (last_ent) active <= 1'b0;
            else          idx    <= idx + IW'(1);
         end else if (cp_valid && cp_ready) begin
            off <= off + LW'(1);
         end
      end
   end

   // R11: a refused word stays on the port
   assert_hold_when_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_valid && !cp_ready && !start) |=> (cp_valid && $stable(cp_addr)));
endmodule

// File: rtl/stm_watchdog.sv
module stm_watchdog #(
   parameter int LIMIT = 64,
   localparam int CW = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic kick,
   output logic expired
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("stm_watchdog: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;
   assign expired = en && !kick && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!en || kick)    cnt <= '0;
      else if (!expired)       cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/stm_ctrl.sv
module stm_ctrl
   import stm_pkg::*;
#(
   parameter int N        = 8,
   parameter int AW       = 16,
   parameter int LW       = 8,
   parameter int WD_LIMIT = 64,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [IW-1:0] cmd_idx,
   input  logic [AW-1:0] cmd_base,
   input  logic [LW-1:0] cmd_len,
   output logic          cmd_rej,
   input  logic          acc_valid,
   input  logic          acc_write,
   input  logic [AW-1:0] acc_addr,
   output logic          acc_ok,
   input  logic          wd_kick,
   input  logic          cp_ready,
   output logic          cp_valid,
   output logic          cp_dir,
   output logic [AW-1:0] cp_addr,
   output logic [2:0]    phase,
   output logic          cpu_fail
);
   if (AW < LW) begin : g_bad_widths
      $error("stm_ctrl: AW must be at least LW");
   end

   phase_e               ph_q, ph_d;
   logic                 failed;
   logic [N-1:0]         hit, open_q, mod_q, clr_mod;
   logic [N-1:0][AW-1:0] base_q;
   logic [N-1:0][LW-1:0] len_q;
   logic                 wd_exp, fail_ev, cmd_go, early;
   logic                 def_en, open_en, close_en, commit_go, close_all;
   logic                 eng_start, eng_dir, eng_done;

   assign early     = (ph_q == PH_IDLE) || (ph_q == PH_WORK);
   assign acc_ok    = acc_valid && !failed && (ph_q == PH_WORK) && (|hit);
   assign fail_ev   = !failed && (wd_exp || (acc_valid && !acc_ok));
   assign cmd_go    = cmd_valid && !failed && !fail_ev && early;
   assign cmd_rej   = cmd_valid && !cmd_go;
   assign def_en    = cmd_go && (cmd_op == OP_DEF);
   assign open_en   = cmd_go && (cmd_op == OP_OPEN);
   assign close_en  = cmd_go && (cmd_op == OP_CLOSE);
   assign commit_go = cmd_go && (cmd_op == OP_COMMIT);
   assign close_all = (ph_q == PH_PRE) || (fail_ev && early);
   assign phase     = ph_q;
   assign cpu_fail  = failed;

   always_comb begin
      eng_start = 1'b0;
      eng_dir   = 1'b0;
      if (ph_q == PH_PRE) begin
         eng_start = 1'b1;
      end else if (fail_ev && early) begin
         eng_start = 1'b1;
         eng_dir   = 1'b1;
      end else if (fail_ev && ph_q == PH_COPY) begin
         eng_start = 1'b1;
      end
   end

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: if (fail_ev) ph_d = PH_ROLL;
                  else if (open_en) ph_d = PH_WORK;
                  else if (commit_go) ph_d = PH_PRE;
         PH_WORK: if (fail_ev) ph_d = PH_ROLL;
                  else if (commit_go) ph_d = PH_PRE;
         PH_PRE:  ph_d = PH_COPY;
         PH_COPY: if (!fail_ev && eng_done) ph_d = PH_IDLE;
         PH_ROLL: if (eng_done) ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         failed <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         failed <= failed | fail_ev;
      end
   end

   stm_obj_table #(.N(N), .AW(AW), .LW(LW)) table_i (
      .clk(clk), .rst_n(rst_n), .def_en(def_en), .open_en(open_en),
      .close_en(close_en), .idx(cmd_idx), .base_in(cmd_base), .len_in(cmd_len),
      .close_all(close_all), .wr_en(acc_ok && acc_write), .addr(acc_addr),
      .clr_mod(clr_mod), .hit(hit), .open_q(open_q), .mod_q(mod_q),
      .base_q(base_q), .len_q(len_q));

   stm_copy_engine #(.N(N), .AW(AW), .LW(LW)) copy_i (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .start_dir(eng_dir),
      .mod_q(mod_q), .base_q(base_q), .len_q(len_q), .cp_ready(cp_ready),
      .cp_valid(cp_valid), .cp_dir(cp_dir), .cp_addr(cp_addr),
      .clr_mod(clr_mod), .done(eng_done));

   stm_watchdog #(.LIMIT(WD_LIMIT)) wd_i (
      .clk(clk), .rst_n(rst_n), .en(!failed), .kick(wd_kick), .expired(wd_exp));

   // R4: the seal step lasts one cycle and leads into the copy
   assert_seal_then_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PRE) |=> (ph_q == PH_COPY));
   // R5: a commit only moves words toward the backup bank
   assert_commit_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_COPY && cp_valid) |-> !cp_dir);
   // R6: rollback only moves words toward the primary bank
   assert_rollback_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_ROLL && cp_valid) |-> cp_dir);
   // R7: disconnection is permanent and blocks access
   assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fail |=> cpu_fail);
   assert_no_access_after_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fail |-> !acc_ok);
   // R9: sealed phases take no commands
   assert_reject_when_sealed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !early) |-> cmd_rej);
endmodule

// File: tb/stm_ctrl_tb.sv
module stm_ctrl_tb_top;
   localparam int N = 8, AW = 16, LW = 8, WD = 64, IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [IW-1:0] cmd_idx = '0;
   logic [AW-1:0] cmd_base = '0;
   logic [LW-1:0] cmd_len = '0;
   logic          cmd_rej;
   logic          acc_valid = 1'b0, acc_write = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_ok;
   logic          wd_kick = 1'b0;
   logic          cp_ready = 1'b0;
   logic          cp_valid, cp_dir, cpu_fail;
   logic [AW-1:0] cp_addr;
   logic [2:0]    phase;

   int checks = 0, errors = 0, xfers = 0, cyc = 0;
   bit kick_en = 1'b1;
   int exp_q[$];

   always #2 clk = ~clk;

   stm_ctrl #(.N(N), .AW(AW), .LW(LW), .WD_LIMIT(WD)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_base(cmd_base), .cmd_len(cmd_len), .cmd_rej(cmd_rej),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr), .acc_ok(acc_ok),
      .wd_kick(wd_kick), .cp_ready(cp_ready), .cp_valid(cp_valid), .cp_dir(cp_dir),
      .cp_addr(cp_addr), .phase(phase), .cpu_fail(cpu_fail));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // kicker
   initial forever begin
      @(posedge clk); #1;
      wd_kick = kick_en && (cyc % 16 == 0);
      cyc++;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cp_valid && cp_ready) begin
         xfers++;
         if (exp_q.size() == 0) chk("R5 unexpected copy word", int'(cp_addr), -1);
         else begin
            automatic int e = exp_q.pop_front();
            chk("R5 copy stream", int'({cp_dir, cp_addr}), e);
         end
      end
   end

   task automatic push_obj(int dir, int base, int len);
      for (int k = 0; k < len; k++) exp_q.push_back((dir << AW) | (base + k));
   endtask

   task automatic do_reset();
      rst_n = 1'b0; kick_en = 1'b1; cp_ready = 1'b0;
      acc_valid = 1'b0; cmd_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic cmd(int op, int idx, int base, int len, int exp_rej, string req);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_idx = IW'(idx);
      cmd_base = AW'(base); cmd_len = LW'(len);
      @(negedge clk);
      chk(req, int'(cmd_rej), exp_rej);
      @(posedge clk); #1 cmd_valid = 1'b0;
   endtask

   task automatic access(int addr, int wr, int exp_ok, string req);
      @(posedge clk); #1;
      acc_valid = 1'b1; acc_write = wr[0]; acc_addr = AW'(addr);
      @(negedge clk);
      chk(req, int'(acc_ok), exp_ok);
      @(posedge clk); #1 acc_valid = 1'b0;
   endtask

   task automatic wait_idle(string req);
      int n = 0;
      do begin @(negedge clk); n++; end while (phase != 3'd0 && n < 300);
      chk(req, int'(phase), 0);
      chk({req, " expected words all seen"}, exp_q.size(), 0);
   endtask

   task automatic run_all();
      // reset state
      do_reset();
      @(negedge clk);
      chk("R1 reset phase", int'(phase), 0);
      chk("R1 reset cpu_fail", int'(cpu_fail), 0);
      chk("R1 reset cp_valid", int'(cp_valid), 0);

      // declare, open, write, commit
      cmd(1, 0, 'h100, 4, 0, "R1 declare 0");
      cmd(1, 1, 'h200, 3, 0, "R1 declare 1");
      cmd(1, 2, 'h300, 2, 0, "R1 declare 2");
      @(negedge clk); chk("R1 declare keeps idle", int'(phase), 0);
      cmd(2, 0, 0, 0, 0, "R2 open 0");
      @(negedge clk); chk("R2 phase working", int'(phase), 1);
      cmd(2, 1, 0, 0, 0, "R2 open 1");
      access('h101, 1, 1, "R2 write inside 0");
      access('h103, 0, 1, "R2 last word of 0");
      access('h200, 1, 1, "R2 write inside 1");
      access('h202, 0, 1, "R2 read inside 1");
      push_obj(0, 'h100, 4);
      push_obj(0, 'h200, 3);
      cp_ready = 1'b1;
      cmd(4, 0, 0, 0, 0, "R4 commit accepted");
      @(negedge clk); chk("R4 precommit phase", int'(phase), 2);
      @(negedge clk); chk("R4 copy phase follows", int'(phase), 3);
      cmd(2, 2, 0, 0, 1, "R9 open refused while copying");
      wait_idle("R5 commit completes");
      // marks were cleared: a second commit copies nothing
      cmd(2, 0, 0, 0, 0, "R5 reopen 0");
      cmd(4, 0, 0, 0, 0, "R5 second commit");
      wait_idle("R5 empty second commit");
      // objects are closed after commit: access is faulty
      access('h101, 0, 0, "R3 access after commit closed");
      @(negedge clk); chk("R3 fault raises cpu_fail", int'(cpu_fail), 1);
      wait_idle("R6 empty rollback");
      cmd(1, 3, 'h10, 2, 1, "R7 command refused after fail");
      access('h10, 0, 0, "R7 access refused after fail");
      chk("R7 fail sticky", int'(cpu_fail), 1);

      // closed object and one-past-end
      do_reset();
      cmd(1, 0, 'h40, 8, 0, "R1 declare");
      cmd(2, 0, 0, 0, 0, "R2 open");
      access('h47, 0, 1, "R2 last word");
      cmd(3, 0, 0, 0, 0, "R3 close");
      access('h41, 0, 0, "R3 inside closed object");
      @(negedge clk); chk("R3 closed access fails", int'(cpu_fail), 1);
      wait_idle("R6 rollback after close fault");
      do_reset();
      cmd(1, 0, 'h40, 8, 0, "R1 declare");
      cmd(2, 0, 0, 0, 0, "R2 open");
      access('h48, 0, 0, "R3 one past end");
      @(negedge clk); chk("R3 past-end fails", int'(cpu_fail), 1);
      wait_idle("R6 rollback after bound fault");

      // rollback on a working-phase failure, with stall
      do_reset();
      cmd(1, 3, 'h500, 3, 0, "R1 declare 3");
      cmd(1, 5, 'h600, 2, 0, "R1 declare 5");
      cmd(1, 6, 'h700, 2, 0, "R1 declare 6");
      cmd(2, 3, 0, 0, 0, "R2 open 3");
      cmd(2, 5, 0, 0, 0, "R2 open 5");
      cmd(2, 6, 0, 0, 0, "R2 open 6");
      access('h600, 1, 1, "R2 write 5");
      access('h701, 1, 1, "R2 write 6");
      access('h999, 0, 0, "R3 stray access");
      @(negedge clk); chk("R6 rollback phase", int'(phase), 4);
      repeat (10) @(negedge clk);
      chk("R11 stalled valid", int'(cp_valid), 1);
      chk("R6 rollback direction", int'(cp_dir), 1);
      chk("R6 first rollback word", int'(cp_addr), 'h600);
      repeat (3) @(negedge clk);
      chk("R11 address held", int'(cp_addr), 'h600);
      chk("R11 valid held", int'(cp_valid), 1);
      push_obj(1, 'h600, 2);
      push_obj(1, 'h700, 2);
      @(posedge clk); #1 cp_ready = 1'b1;
      wait_idle("R6 rollback completes");

      // failure in the middle of the copy restarts it
      do_reset();
      cmd(1, 0, 'h100, 4, 0, "R1 declare 0");
      cmd(1, 1, 'h200, 3, 0, "R1 declare 1");
      cmd(2, 0, 0, 0, 0, "R2 open 0");
      cmd(2, 1, 0, 0, 0, "R2 open 1");
      access('h100, 1, 1, "R2 write 0");
      access('h200, 1, 1, "R2 write 1");
      push_obj(0, 'h100, 2);
      push_obj(0, 'h100, 4);
      push_obj(0, 'h200, 3);
      xfers = 0;
      cp_ready = 1'b1;
      cmd(4, 0, 0, 0, 0, "R8 commit");
      begin
         int n = 0;
         do begin @(posedge clk); #1; n++; end while (xfers < 2 && n < 100);
      end
      cp_ready = 1'b0;
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = AW'('h50);
      @(posedge clk); #1 acc_valid = 1'b0;
      @(negedge clk);
      chk("R8 fault during copy", int'(cpu_fail), 1);
      chk("R8 stays in copy", int'(phase), 3);
      @(posedge clk); #1 cp_ready = 1'b1;
      wait_idle("R8 restarted copy completes");

      // watchdog
      do_reset();
      cmd(1, 0, 'h10, 2, 0, "R1 declare");
      cmd(2, 0, 0, 0, 0, "R2 open");
      access('h10, 1, 1, "R2 write");
      push_obj(1, 'h10, 2);
      cp_ready = 1'b1;
      kick_en = 1'b0;
      repeat (WD - 20) @(negedge clk);
      chk("R10 no timeout yet", int'(cpu_fail), 0);
      repeat (30) @(negedge clk);
      chk("R10 timeout raises fail", int'(cpu_fail), 1);
      wait_idle("R10 rollback after timeout");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            chk("watchdog run time", 1, 0);
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule